// File: doc/BRIEF.md
# Warp Issue Scheduler

This block decides, every clock cycle, which resident warp of a streaming multiprocessor sends its next instruction down the pipeline. It keeps a fixed set of warp slots (24 by default, each slot standing for a warp of 32 threads). A thread block is admitted as a whole: its thread count is turned into a warp count, and the block receives that many slots at once or none at all. Each slot then competes on its own for issue, without reference to the block it came from.

A slot is eligible when it holds a warp and its operand-ready bit in the scoreboard input vector is set. Among eligible slots the one with the smallest index wins. The issue outputs follow the scoreboard in the same cycle, so moving from one warp to another costs no dead cycle. Retiring warps hand their slots back, and those slots can be taken again from the next cycle on. Instruction fetch, register storage, execution lanes and branch divergence are handled outside this block.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is held, no slot is resident, `issue_valid` is 0, and a request for exactly as many warps as there are slots reports `alloc_ready` = 1 with every bit of `alloc_slots` set. A request one thread larger reports `alloc_ready` = 0.
- R2: A request for T threads needs ceil(T/32) warps. `alloc_ready` is 1 exactly when the number of free slots is at least that need. When `alloc_ready` is 0, `alloc_slots` is all zero and an asserted `alloc_req` changes no slot.
- R3: When the block fits, `alloc_slots` marks the lowest-indexed free slots, as many as the need. Bit i stands for slot i. When `alloc_req` and `alloc_ready` are both 1 at a rising edge, those slots are resident from the next cycle on.
- R4: `issue_valid` is 1 only for a slot that is resident and whose `ready_vec` bit is set. A ready bit on a slot that holds no warp has no effect.
- R5: When several slots are eligible, `issue_warp` carries the binary index of the lowest-indexed one.
- R6: When no slot is eligible, `issue_valid` is 0 and `issue_warp` is 0 in that cycle.
- R7: The issue outputs respond combinationally to `ready_vec`. Two consecutive cycles can therefore issue two different warps with no idle cycle between them.
- R8: Setting bit i of `retire_mask` at a rising edge frees slot i from the next cycle on. In the retiring cycle the slot still counts as resident, both for issue and for allocation. A retire bit on a slot that is already free has no effect.
- R9: A request for zero threads is always accepted and takes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Asks to admit a thread block in this cycle |
| alloc_threads | input | THREAD_W | Thread count of the block being offered |
| alloc_ready | output | 1 | The offered block fits in the free slots |
| alloc_slots | output | NUM_SLOTS | Slots the offered block would occupy |
| retire_mask | input | NUM_SLOTS | Slots whose warps finish at this edge |
| ready_vec | input | NUM_SLOTS | Per-slot operand-ready scoreboard bits |
| issue_valid | output | 1 | A warp issues in this cycle |
| issue_warp | output | clog2(NUM_SLOTS) | Slot index of the issuing warp |

## Verification
The bench builds the block with its default parameters: 24 slots, 32-thread warps and a 10-bit thread count. With these values a request can ask for up to 32 warps, more than the slots available. The bench can therefore reach the refusal of a block that could never fit, the refusal of a block that fits an empty scheduler but not the current one, and the exact full-capacity case of 768 threads. Slot 23 serves as the upper edge of the priority order. A random phase mixes admissions, retires in the same cycle and sparse ready patterns, so the free vector becomes fragmented and the lowest-free-slot placement is exercised across gaps.

// File: rtl/wis_pkg.sv
package wis_pkg;
   timeunit 1ns; timeprecision 1ps;

   // Implementation choice for the lowest-index issue picker.
   typedef enum logic {
      PICK_CHAIN = 1'b0,   // prefix-OR chain, one-hot grant, OR-encode
      PICK_SCAN  = 1'b1    // descending scan loop
   } wis_pick_e;

endpackage

// File: rtl/wis_slot_alloc.sv
// Places a block of 'need' warps onto the lowest-indexed free slots.
module wis_slot_alloc #(
   parameter int NS     = 24,
   parameter int NEED_W = 6
) (
   input  logic [NS-1:0]     free_vec,
   input  logic [NEED_W-1:0] need,
   output logic              fit,
   output logic [NS-1:0]     take
);
   timeunit 1ns; timeprecision 1ps;

   localparam int CNT_W = $clog2(NS + 1);
   localparam int CMP_W = ((CNT_W > NEED_W) ? CNT_W : NEED_W) + 1;

   logic [CNT_W-1:0] run [0:NS];
   logic [NS-1:0]    take_raw;

   assign run[0] = '0;

   for (genvar g = 0; g < NS; g++) begin : g_slot
      assign run[g+1]     = run[g] + CNT_W'(free_vec[g]);
      assign take_raw[g]  = free_vec[g] && (CMP_W'(run[g]) < CMP_W'(need));
   end

   assign fit  = CMP_W'(run[NS]) >= CMP_W'(need);
   assign take = fit ? take_raw : '0;

endmodule

// File: rtl/wis_issue_pick.sv
// Lowest-index selection among eligible warp slots.
module wis_issue_pick
   import wis_pkg::*;
#(
   parameter int        NS    = 24,
   parameter wis_pick_e STYLE = PICK_CHAIN
) (
   input  logic [NS-1:0]         elig,
   output logic                  valid,
   output logic [$clog2(NS)-1:0] idx
);
   timeunit 1ns; timeprecision 1ps;

   localparam int SW = $clog2(NS);

   if (STYLE == PICK_CHAIN) begin : g_chain
      logic [NS:0]   seen;
      logic [NS-1:0] grant;
      assign seen[0] = 1'b0;
      for (genvar g = 0; g < NS; g++) begin : g_bit
         assign seen[g+1] = seen[g] | elig[g];
         assign grant[g]  = elig[g] & ~seen[g];
      end
      assign valid = seen[NS];
      always_comb begin
         idx = '0;
         for (int i = 0; i < NS; i++) begin
            idx = idx | (grant[i] ? SW'(i) : '0);
         end
      end
   end else begin : g_scan
      assign valid = |elig;
      always_comb begin
         idx = '0;
         for (int i = NS - 1; i >= 0; i--) begin
            if (elig[i]) idx = SW'(i);
         end
      end
   end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import wis_pkg::*;
#(
   parameter int        NUM_SLOTS  = 24,
   parameter int        WARP_LANES = 32,
   parameter int        THREAD_W   = 10,
   parameter wis_pick_e PICK_STYLE = PICK_CHAIN
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         alloc_req,
   input  logic [THREAD_W-1:0]          alloc_threads,
   output logic                         alloc_ready,
   output logic [NUM_SLOTS-1:0]         alloc_slots,
   input  logic [NUM_SLOTS-1:0]         retire_mask,
   input  logic [NUM_SLOTS-1:0]         ready_vec,
   output logic                         issue_valid,
   output logic [$clog2(NUM_SLOTS)-1:0] issue_warp
);
   timeunit 1ns; timeprecision 1ps;

   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam int LANE_W = $clog2(WARP_LANES);
   localparam int NEED_W = THREAD_W - LANE_W + 1;

   // Elaboration-time parameter checks
   if (NUM_SLOTS < 2) begin : g_chk_slots
      $error("warp_issue_sched: NUM_SLOTS must be at least 2");
   end
   if (WARP_LANES < 2 || (1 << LANE_W) != WARP_LANES) begin : g_chk_lanes
      $error("warp_issue_sched: WARP_LANES must be a power of two >= 2");
   end
   if (THREAD_W <= LANE_W) begin : g_chk_thr
      $error("warp_issue_sched: THREAD_W must exceed log2(WARP_LANES)");
   end

   logic [NUM_SLOTS-1:0] resident_q;
   logic [NUM_SLOTS-1:0] free_vec;
   logic [NUM_SLOTS-1:0] eligible;
   logic [THREAD_W:0]    lane_sum;
   logic [NEED_W-1:0]    need;
   logic                 admit;

   // Warp count: threads rounded up to whole warps
   assign lane_sum = {1'b0, alloc_threads} + (THREAD_W+1)'(WARP_LANES - 1);
   assign need     = lane_sum[THREAD_W:LANE_W];
   assign free_vec = ~resident_q;
   assign admit    = alloc_req && alloc_ready;

   wis_slot_alloc #(
      .NS     (NUM_SLOTS),
      .NEED_W (NEED_W)
   ) u_alloc (
      .free_vec (free_vec),
      .need     (need),
      .fit      (alloc_ready),
      .take     (alloc_slots)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resident_q <= '0;
      end else begin
         resident_q <= (resident_q & ~retire_mask) | (admit ? alloc_slots : '0);
      end
   end

   assign eligible = resident_q & ready_vec;

   wis_issue_pick #(
      .NS    (NUM_SLOTS),
      .STYLE (PICK_STYLE)
   ) u_pick (
      .elig  (eligible),
      .valid (issue_valid),
      .idx   (issue_warp)
   );

   // ---------------- assertions ----------------
   logic [NUM_SLOTS-1:0] below_mask;
   assign below_mask = (NUM_SLOTS'(1) << issue_warp) - NUM_SLOTS'(1);

   a_r2_grant_count: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_ready |-> ($countones(alloc_slots) == int'(need)));

   a_r3_admitted_resident: assert property (@(posedge clk) disable iff (!rst_n)
      admit |=> ((resident_q & $past(alloc_slots)) == $past(alloc_slots)));

   a_r4_issue_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (resident_q[issue_warp] && ready_vec[issue_warp]));

   a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> ((resident_q & ready_vec & below_mask) == '0));

   a_r6_idle_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
      ((resident_q & ready_vec) == '0) |-> !issue_valid);

   a_r8_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
      ((retire_mask & resident_q) != '0) |=>
         (($past(retire_mask & resident_q) & resident_q) == '0));

endmodule

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;
   timeunit 1ns; timeprecision 1ps;

   localparam int NS    = 24;
   localparam int LANES = 32;
   localparam int TW    = 10;
   localparam int SW    = $clog2(NS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_req = 1'b0;
   logic [TW-1:0] alloc_threads = '0;
   logic          alloc_ready;
   logic [NS-1:0] alloc_slots;
   logic [NS-1:0] retire_mask = '0;
   logic [NS-1:0] ready_vec = '0;
   logic          issue_valid;
   logic [SW-1:0] issue_warp;

   always #2.5 clk = ~clk;

   warp_issue_sched i_warp_issue_sched (
      .clk           (clk),
      .rst_n         (rst_n),
      .alloc_req     (alloc_req),
      .alloc_threads (alloc_threads),
      .alloc_ready   (alloc_ready),
      .alloc_slots   (alloc_slots),
      .retire_mask   (retire_mask),
      .ready_vec     (ready_vec),
      .issue_valid   (issue_valid),
      .issue_warp    (issue_warp)
   );

   int total = 0;
   int bad   = 0;

   // reference state
   logic [NS-1:0] res_m  = '0;
   logic [NS-1:0] p_take = '0;
   logic [NS-1:0] p_ret  = '0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // Drive one cycle of inputs after the falling edge and compare with the model.
   task automatic drive(input bit req, input int thr,
                        input logic [NS-1:0] ret, input logic [NS-1:0] rdy);
      int need, nfree, cnt, e_idx;
      bit e_fit, e_valid;
      logic [NS-1:0] e_slots;
      @(negedge clk);
      alloc_req     = req;
      alloc_threads = TW'(thr);
      retire_mask   = ret;
      ready_vec     = rdy;
      #1;
      need  = (thr + LANES - 1) / LANES;
      nfree = 0;
      for (int i = 0; i < NS; i++) if (!res_m[i]) nfree++;
      e_fit   = (nfree >= need);
      e_slots = '0;
      cnt     = 0;
      if (e_fit) begin
         for (int i = 0; i < NS; i++) begin
            if (!res_m[i] && cnt < need) begin
               e_slots[i] = 1'b1;
               cnt++;
            end
         end
      end
      e_valid = 1'b0;
      e_idx   = 0;
      for (int i = NS - 1; i >= 0; i--) begin
         if (res_m[i] && rdy[i]) begin
            e_valid = 1'b1;
            e_idx   = i;
         end
      end
      check("R2", "alloc_ready", 32'(alloc_ready), 32'(e_fit));
      check("R3", "alloc_slots", 32'(alloc_slots), 32'(e_slots));
      check("R6", "issue_valid", 32'(issue_valid), 32'(e_valid));
      check("R5", "issue_warp",  32'(issue_warp),  32'(e_idx));
      p_take = (req && e_fit) ? e_slots : '0;
      p_ret  = ret;
   endtask

   task automatic commit();
      @(posedge clk);
      res_m = (res_m & ~p_ret) | p_take;
   endtask

   task automatic cyc(input bit req, input int thr,
                      input logic [NS-1:0] ret, input logic [NS-1:0] rdy);
      drive(req, thr, ret, rdy);
      commit();
   endtask

   initial begin
      #(50000 * 5);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: state during reset
      repeat (2) @(posedge clk);
      @(negedge clk);
      ready_vec     = '1;
      alloc_threads = TW'(768);
      #1;
      check("R1", "issue_valid in reset", 32'(issue_valid), 32'd0);
      check("R1", "alloc_ready full size", 32'(alloc_ready), 32'd1);
      check("R1", "alloc_slots full size", 32'(alloc_slots), 32'hFF_FFFF);
      alloc_threads = TW'(769);
      #1;
      check("R1", "alloc_ready oversize", 32'(alloc_ready), 32'd0);
      ready_vec = '0;
      alloc_threads = '0;
      @(negedge clk);
      rst_n = 1'b1;

      // R3: 128 threads -> four warps, slots 0..3
      drive(1, 128, '0, '0);
      check("R3", "first block slots", 32'(alloc_slots), 32'h0F);
      commit();
      // 33 threads -> two warps, slots 4,5
      drive(1, 33, '0, '1);
      check("R3", "round-up slots", 32'(alloc_slots), 32'h30);
      check("R5", "lowest of 0..3", 32'(issue_warp), 32'd0);
      commit();
      // R9: zero threads take nothing
      drive(1, 0, '0, '0);
      check("R9", "zero ready", 32'(alloc_ready), 32'd1);
      check("R9", "zero slots", 32'(alloc_slots), 32'd0);
      commit();
      drive(1, 1, '0, '0);
      check("R9", "slot after zero request", 32'(alloc_slots), 32'h40);
      commit();

      // R7: back-to-back different warps
      drive(0, 0, '0, 24'h000001);
      check("R7", "issue warp 0", 32'(issue_warp), 32'd0);
      commit();
      drive(0, 0, '0, 24'h000008);
      check("R7", "next cycle warp 3", 32'(issue_warp), 32'd3);
      check("R7", "no bubble", 32'(issue_valid), 32'd1);
      commit();
      drive(0, 0, '0, 24'h000060);
      check("R5", "5 beats 6", 32'(issue_warp), 32'd5);
      commit();

      // R4: ready bit on empty slot 10 ignored
      drive(0, 0, '0, 24'h000400);
      check("R4", "ready on empty slot", 32'(issue_valid), 32'd0);
      commit();

      // R8: retire 1,2 while allocating 64 threads
      drive(1, 64, 24'h000006, 24'h000002);
      check("R8", "retiring warp still issues", 32'(issue_warp), 32'd1);
      check("R8", "retiring slots not yet free", 32'(alloc_slots), 32'h180);
      commit();
      drive(1, 64, '0, 24'h000002);
      check("R8", "retired warp gone", 32'(issue_valid), 32'd0);
      check("R8", "freed slots reused", 32'(alloc_slots), 32'h006);
      commit();
      // retire of free slot 23 ignored: 9 resident, 15 free
      cyc(0, 0, 24'h800000, '0);
      drive(0, 480, '0, '0);
      check("R8", "15 warps fit", 32'(alloc_ready), 32'd1);
      commit();
      drive(0, 481, '0, '0);
      check("R8", "16 warps do not fit", 32'(alloc_ready), 32'd0);
      commit();

      // R2: never-fitting and partially-fitting refusals
      drive(1, 1000, '0, '1);
      check("R2", "oversize refused", 32'(alloc_slots), 32'd0);
      commit();
      cyc(1, 480, '0, '0);
      drive(1, 1, '0, 24'h800000);
      check("R2", "full scheduler refuses", 32'(alloc_ready), 32'd0);
      check("R5", "slot 23 issues alone", 32'(issue_warp), 32'd23);
      commit();

      // random phase
      for (int n = 0; n < 2000; n++) begin
         logic [NS-1:0] rr, rd;
         rr = NS'($urandom & $urandom & $urandom & $urandom);
         rd = NS'($urandom & $urandom);
         cyc(($urandom % 3) != 0, int'($urandom_range(0, 300)), rr, rd);
      end

      // drain everything and confirm idle
      cyc(0, 0, '1, '1);
      drive(0, 768, '0, '1);
      check("R6", "idle after drain", 32'(issue_valid), 32'd0);
      check("R6", "idle warp index", 32'(issue_warp), 32'd0);
      check("R2", "all free after drain", 32'(alloc_ready), 32'd1);
      commit();

      finish_run();
   end

endmodule